// File: doc/BRIEF.md
# Nested Fault Escalation Unit

This unit sits between the fault sources of a processor core and the delivery logic. Each fault raised by the core is compared with the most serious fault still being delivered. The unit then decides one of three outcomes. The new fault can go out unchanged. It can be promoted to a double fault (vector 8) with a zero error code. Or, when a double fault is already being delivered, the unit raises a shutdown request and delivers nothing.

Faults fall into three classes. Contributory faults are vectors 0, 10, 11, 12 and 13. The page fault is vector 14. All other vectors are benign. A record register keeps the class of the last fault that matters for nesting. Software-originated interrupts skip the decision and never touch the record. The delivery logic pulses a clear strobe once a fault has been delivered successfully, which sets the record back to idle.

Top module: `fault_nest_escalator`

## Requirements
- R1: Each request produces exactly one result, with `out_valid` high for one cycle, in the cycle after `req_valid`. With no request, `out_valid` stays low.
- R2: The contributory set is vectors 0, 10, 11, 12 and 13. A contributory fault raised while the record holds a contributory fault comes out as vector 8 with error code 0.
- R3: A page fault (vector 14) or a contributory fault raised while the record holds a page fault comes out as vector 8 with error code 0. A page fault raised while the record holds a contributory fault is delivered unchanged as vector 14.
- R4: Any non-software fault raised while the record holds a double fault produces a result with `out_shutdown` high and vector and error fields of 0. The record stays double fault, so the next fault shuts down as well.
- R5: A benign result (any vector other than 0, 8, 10-14) is delivered unchanged and leaves the record as it was. For example, contributory, then benign, then contributory still promotes.
- R6: A request with `req_swint` high is delivered with its vector and error code unchanged and no shutdown, even against a double-fault record. It leaves the record unchanged.
- R7: After reset `out_valid` and `out_shutdown` are low and the record is idle, so the first fault of any vector is delivered unchanged.
- R8: A `clear` pulse sets the record to idle. A request in the same cycle as `clear` is classified against idle, and its own record update takes effect.
- R9: Vector 8 raised directly against an idle record is delivered unchanged with its error code and recorded as a double fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New fault or interrupt request this cycle |
| req_vector | input | 8 | Vector number of the request |
| req_err | input | 32 | Error code of the request |
| req_swint | input | 1 | Request comes from a software interrupt |
| clear | input | 1 | Delivery completed; set the record to idle |
| out_valid | output | 1 | One-cycle strobe: result fields are valid |
| out_vector | output | 8 | Final vector to deliver |
| out_err | output | 32 | Final error code |
| out_shutdown | output | 1 | Shutdown (triple fault) request, high only with out_valid |

## Verification
Every result is due exactly one cycle after its request: the decision is combinational and the result passes through one register. The record change made by a request applies to a request in the following cycle. When the driver issues a request, it pushes the expected result together with the cycle in which that result is due. The monitor samples on the falling edge and compares each `out_valid` it sees against the head of the queue, including the due cycle. A result that is missing or comes out of turn is therefore reported. Back-to-back requests check that the record updates in time for the very next cycle.

// File: rtl/fault_nest_pkg.sv
// Shared definitions for the nested fault escalation unit.
// Assumes vector numbers fit in the VEC_W parameter of the modules (>= 4 bits).
package fault_nest_pkg;

    // Class of a fault, also used as the content of the nesting record.
    // FC_NONE means benign for an incoming fault, and idle for the record.
    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_CONTRIB = 2'd1,
        FC_PAGE    = 2'd2,
        FC_DOUBLE  = 2'd3
    } fclass_t;

    // Vector numbers with a fixed role in escalation.
    localparam int VEC_DOUBLE = 8;
    localparam int VEC_PAGE   = 14;

    // Contributory vectors, given as inclusive spans.
    localparam int N_CONTRIB_SPANS = 2;
    localparam int CONTRIB_LO [N_CONTRIB_SPANS] = '{0, 10};
    localparam int CONTRIB_HI [N_CONTRIB_SPANS] = '{0, 13};

endpackage

// File: rtl/fault_class_decoder.sv
// Maps a vector number onto its fault class.
// Purely combinational. The contributory spans come from the package.
// Assumes the spans do not contain the page or double-fault vectors.
module fault_class_decoder
    import fault_nest_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec,
    output fclass_t          cls
);

    localparam logic [VEC_W-1:0] V_DF = VEC_W'(VEC_DOUBLE);
    localparam logic [VEC_W-1:0] V_PF = VEC_W'(VEC_PAGE);

    logic [N_CONTRIB_SPANS-1:0] span_hit;

    // One range comparator for each contributory span.
    generate
        for (genvar s = 0; s < N_CONTRIB_SPANS; s++) begin : g_span
            localparam logic [VEC_W-1:0] LO = VEC_W'(CONTRIB_LO[s]);
            localparam logic [VEC_W-1:0] HI = VEC_W'(CONTRIB_HI[s]);
            if (CONTRIB_LO[s] == 0) begin : g_from_zero
                assign span_hit[s] = (vec <= HI);
            end else begin : g_range
                assign span_hit[s] = (vec >= LO) && (vec <= HI);
            end
        end
    endgenerate

    // Select the class: page and double first, then the contributory spans.
    always_comb begin
        if (vec == V_PF)
            cls = FC_PAGE;
        else if (vec == V_DF)
            cls = FC_DOUBLE;
        else if (|span_hit)
            cls = FC_CONTRIB;
        else
            cls = FC_NONE;
    end

endmodule

// File: rtl/fault_nest_resolver.sv
// Decides the outcome of one request against the effective record.
// Combinational. The record is already forced to idle when clear is active.
// Outputs the delivered vector and error code, the shutdown flag, and the
// record update.
module fault_nest_resolver
    import fault_nest_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input  fclass_t          prev_cls,
    input  fclass_t          new_cls,
    input  logic [VEC_W-1:0] new_vec,
    input  logic [ERR_W-1:0] new_err,
    input  logic             new_swint,
    output logic [VEC_W-1:0] res_vec,
    output logic [ERR_W-1:0] res_err,
    output logic             res_shutdown,
    output logic             rec_we,
    output fclass_t          rec_next
);

    localparam logic [VEC_W-1:0] V_DF = VEC_W'(VEC_DOUBLE);

    logic    promote;
    logic    shutdown;
    fclass_t res_cls;

    // Pair rules: contributory on contributory, page or contributory on page.
    always_comb begin
        unique case (prev_cls)
            FC_CONTRIB: promote = (new_cls == FC_CONTRIB);
            FC_PAGE:    promote = (new_cls == FC_CONTRIB) || (new_cls == FC_PAGE);
            default:    promote = 1'b0;
        endcase
    end

    // A recorded double fault turns any further hardware fault into shutdown.
    always_comb shutdown = (prev_cls == FC_DOUBLE) && !new_swint;

    // Build the delivered result: bypass, shutdown, promotion or pass-through.
    always_comb begin
        res_vec      = new_vec;
        res_err      = new_err;
        res_shutdown = 1'b0;
        res_cls      = new_cls;
        if (!new_swint) begin
            if (shutdown) begin
                res_vec      = '0;
                res_err      = '0;
                res_shutdown = 1'b1;
                res_cls      = FC_DOUBLE;
            end else if (promote) begin
                res_vec = V_DF;
                res_err = '0;
                res_cls = FC_DOUBLE;
            end
        end
    end

    // Record only hardware results that are contributory, page or double.
    always_comb begin
        rec_we   = !new_swint && !shutdown && (res_cls != FC_NONE);
        rec_next = res_cls;
    end

endmodule

// File: rtl/fault_record.sv
// Holds the class of the last fault that matters for nesting.
// Reset and clear both set it to idle. A write in the same cycle as
// clear wins, because the request has already been judged against idle.
// The effective class used for classification is idle while clear is high.
module fault_record
    import fault_nest_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    we,
    input  fclass_t wdata,
    output fclass_t rec_q,
    output fclass_t rec_eff
);

    // Record register: write, else clear to idle, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_q <= FC_NONE;
        else if (we)
            rec_q <= wdata;
        else if (clear)
            rec_q <= FC_NONE;
    end

    // Class seen by a request in this cycle.
    always_comb rec_eff = clear ? FC_NONE : rec_q;

endmodule

// File: rtl/fault_nest_escalator.sv
// Top of the nested fault escalation unit.
// Each request is decoded, judged against the record, and presented one
// cycle later with a single-cycle valid strobe. Result fields hold their
// value between requests. Assumes at most one request per cycle.
module fault_nest_escalator
    import fault_nest_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [ERR_W-1:0] req_err,
    input  logic             req_swint,
    input  logic             clear,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vector,
    output logic [ERR_W-1:0] out_err,
    output logic             out_shutdown
);

    fclass_t          new_cls;
    fclass_t          rec_q;
    fclass_t          rec_eff;
    fclass_t          rec_next;
    logic             rec_we_raw;
    logic [VEC_W-1:0] res_vec;
    logic [ERR_W-1:0] res_err;
    logic             res_shutdown;

    fault_class_decoder #(.VEC_W(VEC_W)) u_dec (
        .vec (req_vector),
        .cls (new_cls)
    );

    fault_nest_resolver #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_res (
        .prev_cls     (rec_eff),
        .new_cls      (new_cls),
        .new_vec      (req_vector),
        .new_err      (req_err),
        .new_swint    (req_swint),
        .res_vec      (res_vec),
        .res_err      (res_err),
        .res_shutdown (res_shutdown),
        .rec_we       (rec_we_raw),
        .rec_next     (rec_next)
    );

    fault_record u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .we      (rec_we_raw && req_valid),
        .wdata   (rec_next),
        .rec_q   (rec_q),
        .rec_eff (rec_eff)
    );

    // Strobes: valid follows the request, shutdown only with a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_shutdown <= 1'b0;
        end else begin
            out_valid    <= req_valid;
            out_shutdown <= req_valid && res_shutdown;
        end
    end

    // Result fields: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vector <= '0;
            out_err    <= '0;
        end else if (req_valid) begin
            out_vector <= res_vec;
            out_err    <= res_err;
        end
    end

endmodule

// File: rtl/fault_nest_checker.sv
// Temporal properties of the nested fault escalation unit, bound to its top.
// It observes the ports and the record register.
module fault_nest_checker
    import fault_nest_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VEC_W-1:0] req_vector,
    input logic [ERR_W-1:0] req_err,
    input logic             req_swint,
    input logic             clear,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vector,
    input logic [ERR_W-1:0] out_err,
    input logic             out_shutdown,
    input fclass_t          rec_q
);

    logic is_contrib;
    always_comb is_contrib = (req_vector == '0) ||
        ((req_vector >= VEC_W'(10)) && (req_vector <= VEC_W'(13)));

    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    p_contrib_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_swint && !clear && rec_q == FC_CONTRIB && is_contrib)
        |=> (out_vector == VEC_W'(8) && out_err == '0 && !out_shutdown));

    p_page_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_swint && !clear && rec_q == FC_PAGE &&
         (is_contrib || req_vector == VEC_W'(14)))
        |=> (out_vector == VEC_W'(8) && out_err == '0));

    p_shutdown_from_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_swint && !clear && rec_q == FC_DOUBLE) |=> out_shutdown);

    p_shutdown_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_shutdown |-> out_valid);

    p_swint_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_swint) |=>
        (out_vector == $past(req_vector) && out_err == $past(req_err) && !out_shutdown));

    p_swint_keeps_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_swint && !clear) |=> rec_q == $past(rec_q));

    p_clear_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !req_valid) |=> rec_q == FC_NONE);

endmodule

bind fault_nest_escalator fault_nest_checker #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vector   (req_vector),
    .req_err      (req_err),
    .req_swint    (req_swint),
    .clear        (clear),
    .out_valid    (out_valid),
    .out_vector   (out_vector),
    .out_err      (out_err),
    .out_shutdown (out_shutdown),
    .rec_q        (rec_q)
);

// File: tb/sim_fault_nest_escalator.sv
// Scoreboard bench: the driver queues expected results with their due cycle,
// and the monitor compares each out_valid against the head of the queue.
module sim_fault_nest_escalator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [31:0] req_err = '0;
    logic        req_swint = 1'b0;
    logic        clear = 1'b0;
    logic        out_valid;
    logic [7:0]  out_vector;
    logic [31:0] out_err;
    logic        out_shutdown;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  v;
        logic [31:0] e;
        logic        sd;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    fault_nest_escalator u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_err(req_err), .req_swint(req_swint), .clear(clear),
        .out_valid(out_valid), .out_vector(out_vector), .out_err(out_err),
        .out_shutdown(out_shutdown)
    );

    task automatic send(input logic [7:0] v, input logic [31:0] e, input logic sw,
                        input logic clr, input logic [7:0] ev, input logic [31:0] ee,
                        input logic esd, input string tag);
        exp_t x;
        @(negedge clk);
        req_valid = 1'b1; req_vector = v; req_err = e; req_swint = sw; clear = clr;
        x.v = ev; x.e = ee; x.sd = esd; x.due = cyc + 1; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_swint = 1'b0; clear = 1'b0;
        end
    endtask

    task automatic clr_only();
        @(negedge clk);
        req_valid = 1'b0; req_swint = 1'b0; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Monitor: compare results against the queue on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                tests++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected result: vec=%0d err=%h sd=%0b expected none",
                             out_vector, out_err, out_shutdown);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    if (x.due != cyc || out_vector !== x.v || out_err !== x.e ||
                        out_shutdown !== x.sd) begin
                        fails++;
                        $display("FAIL %s: cyc=%0d vec=%0d err=%h sd=%0b expected cyc=%0d vec=%0d err=%h sd=%0b",
                                 x.tag, cyc, out_vector, out_err, out_shutdown,
                                 x.due, x.v, x.e, x.sd);
                    end
                end
            end else if (q.size() > 0 && q[0].due <= cyc) begin
                exp_t x;
                x = q.pop_front();
                tests++; fails++;
                $display("FAIL R1 %s: no result at cyc=%0d, expected vec=%0d at cyc=%0d",
                         x.tag, cyc, x.v, x.due);
            end
            if (out_shutdown && !out_valid) begin
                tests++; fails++;
                $display("FAIL R4 shutdown without valid: sd=1 valid=0 expected valid=1");
            end
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;   // R7 reset state
        if (out_valid !== 1'b0 || out_shutdown !== 1'b0) begin
            fails++;
            $display("FAIL R7 reset: valid=%0b sd=%0b expected 0 0", out_valid, out_shutdown);
        end
        rst_n = 1'b1;
        idle(2);

        send(8'd3,  32'h11, 0, 0, 8'd3,  32'h11, 0, "R7 first fault after reset unchanged");
        send(8'd13, 32'h22, 0, 0, 8'd13, 32'h22, 0, "R2 first contributory unchanged");
        idle(1);
        send(8'd3,  32'h33, 0, 0, 8'd3,  32'h33, 0, "R5 benign delivered unchanged");
        send(8'd0,  32'h44, 0, 0, 8'd8,  32'h0,  0, "R2 R5 contributory after benign gap promotes");
        send(8'd6,  32'h55, 0, 0, 8'd0,  32'h0,  1, "R4 fault on double shuts down");
        idle(2);
        send(8'd14, 32'h56, 0, 0, 8'd0,  32'h0,  1, "R4 record stays double");
        send(8'd8,  32'h66, 1, 0, 8'd8,  32'h66, 0, "R6 software interrupt bypass on double");
        idle(1);
        clr_only();
        send(8'd14, 32'h77, 0, 0, 8'd14, 32'h77, 0, "R8 clear returns record to idle");
        send(8'd14, 32'h88, 0, 0, 8'd8,  32'h0,  0, "R3 page after page promotes");
        send(8'd10, 32'h99, 0, 1, 8'd10, 32'h99, 0, "R8 request with clear sees idle");
        send(8'd14, 32'hAA, 0, 0, 8'd14, 32'hAA, 0, "R3 page after contributory unchanged");
        send(8'd11, 32'hBB, 0, 0, 8'd8,  32'h0,  0, "R3 contributory after page promotes");
        idle(1);
        clr_only();
        send(8'd12, 32'hCC, 1, 0, 8'd12, 32'hCC, 0, "R6 software contributory unchanged");
        send(8'd10, 32'hDD, 0, 0, 8'd10, 32'hDD, 0, "R6 software interrupt not recorded");
        idle(1);
        clr_only();
        send(8'd8,  32'hEE, 0, 0, 8'd8,  32'hEE, 0, "R9 direct double fault unchanged");
        send(8'd3,  32'hEF, 0, 0, 8'd0,  32'h0,  1, "R9 direct double fault recorded");
        send(8'd5,  32'hF0, 0, 1, 8'd5,  32'hF0, 0, "R8 clear with request on double no shutdown");
        send(8'd10, 32'hF1, 0, 0, 8'd10, 32'hF1, 0, "R8 record idle after clear with benign");
        send(8'd1,  32'hF2, 0, 0, 8'd1,  32'hF2, 0, "R2 vector 1 not contributory");
        send(8'd12, 32'hF3, 0, 0, 8'd8,  32'h0,  0, "R2 R5 vector 1 left record contributory");
        idle(1);
        clr_only();
        send(8'd9,  32'h101, 0, 0, 8'd9,  32'h101, 0, "R2 vector 9 benign");
        send(8'd15, 32'h102, 0, 0, 8'd15, 32'h102, 0, "R2 vector 15 benign");
        send(8'd0,  32'h103, 0, 0, 8'd0,  32'h103, 0, "R2 vector 0 contributory first");
        send(8'd0,  32'h104, 0, 0, 8'd8,  32'h0,   0, "R2 vector 0 twice promotes");
        idle(4);

        tests++;   // R1 every queued result was produced
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 drain: %0d results missing, expected 0", q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule